// File: doc/BRIEF.md
# Character Display Command Engine

This block is the device-side command engine of a character display controller. A bus front end that has already synchronised the host strobes hands it single transfers: a register-select bit, a read/write bit and a data byte, qualified by a one-cycle valid. Instruction writes are decoded by the position of their highest set bit. They update the control registers (entry direction and auto-scroll, display, cursor and blink enables, bus width, line count and font height), load the address counter, or move the cursor or the visible window.

Data transfers go straight to external RAM ports. The block addresses whichever space was selected last, either the character-pattern space (64 locations) or the display-text space (128 locations). After each access the address counter steps in the direction that entry mode sets. Every accepted operation starts an execution window during which the busy flag is high. Clear and home take 410 oscillator ticks and everything else takes 10, with the clocks per tick set by a parameter. Anything other than a status read that arrives during this window is discarded and flagged.

The state machine has two states. `ST_READY` goes to `ST_EXEC` on an accepted operation, which loads the remaining-clock count. `ST_EXEC` goes back to `ST_READY` when that count reaches zero. In every other case it stays and counts down.

Top module: `chardisp_cmd_engine`

## Requirements
- R1: An instruction write (`xfer_rs`=0, `xfer_rw`=0) is decoded by its highest set bit. Bit 7 loads a text address, bit 6 loads a pattern address, bit 5 is function set, bit 4 is cursor/window shift, bit 3 is display control, bit 2 is entry mode, bit 1 is home and bit 0 is clear. The byte 00h is a no-op: it sets no busy and raises no drop.
- R2: An accepted operation raises `busy` from the next cycle for exactly LONG_TICKS*TICK_CLKS clocks for clear and home, and SHORT_TICKS*TICK_CLKS clocks for every other instruction and for data accesses.
- R3: While `busy` is high, an instruction write or data access has no effect on registers, the address counter or RAM. In the same cycle it raises `dropped`.
- R4: A status read (`xfer_rs`=0, `xfer_rw`=1) is honoured even while busy. On the next cycle `rd_valid` is 1 and `rd_data` holds busy on bit 7 and the address counter on bits 6..0.
- R5: Clear and home set the address counter to 0, select the text space and reset `scroll` to 0. Clear also pulses `ram_clr` in its accept cycle, and home does not.
- R6: Entry mode takes bit 1 as the step direction `inc_dir` (1 = up) and bit 0 as `shift_en`.
- R7: Display control takes bit 2 as `disp_on`, bit 1 as `cursor_on` and bit 0 as `blink_on`.
- R8: In a shift instruction, bit 3 = 1 moves the window and bit 3 = 0 moves the cursor, and bit 2 = 1 means right. A window move left adds 1 to `scroll` and a move right subtracts 1, wrapping modulo 80. A cursor move right adds 1 to the counter and a move left subtracts 1, wrapping within the active space.
- R9: Function set takes bit 4 as `bus_8bit`, bit 3 as `two_line` and bit 2 as `tall_font`.
- R10: A pattern-address load takes data bits 5..0 and selects the pattern space (`ram_sel_cg`=1). A text-address load takes bits 6..0 and selects the text space.
- R11: A data write asserts `ram_we` in its accept cycle with `ram_addr` set to the counter and `ram_wdata` set to the byte. The counter then steps by ±1 per `inc_dir`, modulo 64 in the pattern space and modulo 128 in the text space.
- R12: A data read asserts `ram_re` in its accept cycle. The next cycle carries `ram_rdata` on `rd_data` with `rd_valid`=1, and the counter steps as in R11.
- R13: When `shift_en` is 1, each data access also moves `scroll` by +1 if `inc_dir`=1 and by -1 otherwise, modulo 80.
- R14: After reset, `busy` is 0, the counter is 0 in the text space, `scroll` is 0, `inc_dir` is 1 and every other control output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | One-cycle qualifier for a host transfer |
| xfer_rs | input | 1 | 0 = instruction/status, 1 = RAM data |
| xfer_rw | input | 1 | 1 = read, 0 = write |
| xfer_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result (status or RAM byte) |
| busy | output | 1 | Execution window active |
| dropped | output | 1 | Transfer discarded because busy |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_clr | output | 1 | Request to blank the text space |
| ram_sel_cg | output | 1 | 1 = pattern space, 0 = text space |
| ram_addr | output | 7 | RAM address (address counter) |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, combinational on ram_addr |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| inc_dir | output | 1 | Counter step direction, 1 = up |
| shift_en | output | 1 | Scroll on data access |
| bus_8bit | output | 1 | Bus width select |
| two_line | output | 1 | Two-line mode |
| tall_font | output | 1 | Tall glyph mode |
| scroll | output | 7 | Visible window offset, 0..79 |

## Verification
The assertions assume that `xfer_valid` is a single-cycle pulse with its qualifiers stable in that cycle. They also assume that `ram_rdata` settles within the cycle from `ram_addr`. The bench drives every transfer for exactly one clock, changing inputs on the falling edge. Its RAM model answers reads combinationally. It waits for `busy` to fall before each new command, except where it deliberately sends a second command or a status read into an open execution window.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISPCTL,
        OP_SHIFT,
        OP_FUNC,
        OP_CGADDR,
        OP_DDADDR
    } op_e;

    typedef enum logic {
        ST_READY,
        ST_EXEC
    } exec_st_e;

endpackage

// File: rtl/chardisp_op_decode.sv
module chardisp_op_decode
    import chardisp_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op,
    output logic       long_op
);

    // R1: the highest set bit selects the instruction
    always_comb begin
        priority casez (code)
            8'b1???????: op = OP_DDADDR;
            8'b01??????: op = OP_CGADDR;
            8'b001?????: op = OP_FUNC;
            8'b0001????: op = OP_SHIFT;
            8'b00001???: op = OP_DISPCTL;
            8'b000001??: op = OP_ENTRY;
            8'b0000001?: op = OP_HOME;
            8'b00000001: op = OP_CLEAR;
            default:     op = OP_NONE;
        endcase
    end

    assign long_op = (op == OP_CLEAR) || (op == OP_HOME);

endmodule

// File: rtl/chardisp_exec_fsm.sv
module chardisp_exec_fsm
    import chardisp_pkg::*;
#(
    parameter int TICK_CLKS   = 400,
    parameter int LONG_TICKS  = 410,
    parameter int SHORT_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic busy
);

    localparam int LONG_CLKS  = TICK_CLKS * LONG_TICKS;
    localparam int SHORT_CLKS = TICK_CLKS * SHORT_TICKS;
    localparam int CW         = $clog2(LONG_CLKS + 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CLKS - 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CLKS - 1);

    exec_st_e      st, st_nx;
    logic [CW-1:0] rem, rem_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_READY;
            rem <= '0;
        end else begin
            st  <= st_nx;
            rem <= rem_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        rem_nx = rem;
        unique case (st)
            ST_READY: begin
                if (start) begin
                    st_nx  = ST_EXEC;
                    rem_nx = long_sel ? LONG_LD : SHORT_LD;
                end
            end
            ST_EXEC: begin
                if (rem == '0) st_nx  = ST_READY;
                else           rem_nx = rem - 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (st == ST_EXEC);

    // R2: an accepted operation opens the window on the next cycle
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R2: the count is empty whenever the machine is idle
    p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rem == '0));
    // R2: the window counts down one clock at a time without leaving early
    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rem != '0) |=> (busy && rem == $past(rem) - 1'b1));

endmodule

// File: rtl/chardisp_addr_unit.sv
module chardisp_addr_unit #(
    parameter int AW          = 7,
    parameter int SCROLL_SPAN = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_zero,
    input  logic          ld_cg,
    input  logic          ld_dd,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    input  logic          step_up,
    input  logic          scroll_step,
    input  logic          scroll_up,
    output logic [AW-1:0] ac,
    output logic          cg_sel,
    output logic [6:0]    scroll
);

    localparam logic [6:0] SCROLL_LAST = 7'(SCROLL_SPAN - 1);

    logic [AW-1:0] ac_nx;
    logic [6:0]    scroll_nx;

    // R11: the pattern space wraps on its low bits, the text space on all bits
    always_comb begin
        if (cg_sel)
            ac_nx = {1'b0, step_up ? ac[AW-2:0] + 1'b1 : ac[AW-2:0] - 1'b1};
        else
            ac_nx = step_up ? ac + 1'b1 : ac - 1'b1;
    end

    // R8 R13: window offset wraps modulo SCROLL_SPAN
    always_comb begin
        if (scroll_up) scroll_nx = (scroll == SCROLL_LAST) ? 7'd0 : scroll + 7'd1;
        else           scroll_nx = (scroll == 7'd0) ? SCROLL_LAST : scroll - 7'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac     <= '0;
            cg_sel <= 1'b0;
            scroll <= 7'd0;
        end else begin
            if (ld_zero) begin
                ac     <= '0;
                cg_sel <= 1'b0;
            end else if (ld_cg) begin
                ac     <= {1'b0, ld_val[AW-2:0]};
                cg_sel <= 1'b1;
            end else if (ld_dd) begin
                ac     <= ld_val;
                cg_sel <= 1'b0;
            end else if (step) begin
                ac     <= ac_nx;
            end
            if (ld_zero)          scroll <= 7'd0;
            else if (scroll_step) scroll <= scroll_nx;
        end
    end

    // R10: in the pattern space the top counter bit stays clear
    p_cg_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cg_sel |-> !ac[AW-1]);
    // R8: the window offset never leaves its span
    p_scroll_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scroll <= SCROLL_LAST);
    // R5: a clear or home lands on text address zero with no offset
    p_home_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_zero |=> (ac == '0 && !cg_sel && scroll == 7'd0));

endmodule

// File: rtl/chardisp_cmd_engine.sv
module chardisp_cmd_engine
    import chardisp_pkg::*;
#(
    parameter int TICK_CLKS   = 400,
    parameter int LONG_TICKS  = 410,
    parameter int SHORT_TICKS = 10,
    parameter int SCROLL_SPAN = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_valid,
    input  logic       xfer_rs,
    input  logic       xfer_rw,
    input  logic [7:0] xfer_data,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       dropped,
    output logic       ram_we,
    output logic       ram_re,
    output logic       ram_clr,
    output logic       ram_sel_cg,
    output logic [6:0] ram_addr,
    output logic [7:0] ram_wdata,
    input  logic [7:0] ram_rdata,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       inc_dir,
    output logic       shift_en,
    output logic       bus_8bit,
    output logic       two_line,
    output logic       tall_font,
    output logic [6:0] scroll
);

    localparam int AW = 7;

    op_e           op;
    logic          long_op;
    logic          is_status, op_req, accept, is_instr, is_data, is_shift;
    logic [AW-1:0] ac;
    logic          cg_sel;

    chardisp_op_decode u_dec (
        .code    (xfer_data),
        .op      (op),
        .long_op (long_op)
    );

    assign is_status = xfer_valid && !xfer_rs && xfer_rw;
    assign op_req    = xfer_valid && !is_status && !(!xfer_rs && op == OP_NONE);
    assign accept    = op_req && !busy;
    assign dropped   = op_req && busy;
    assign is_instr  = accept && !xfer_rs;
    assign is_data   = accept && xfer_rs;
    assign is_shift  = is_instr && (op == OP_SHIFT);

    chardisp_exec_fsm #(
        .TICK_CLKS   (TICK_CLKS),
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .long_sel (!xfer_rs && long_op),
        .busy     (busy)
    );

    chardisp_addr_unit #(
        .AW          (AW),
        .SCROLL_SPAN (SCROLL_SPAN)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_zero     (is_instr && long_op),
        .ld_cg       (is_instr && op == OP_CGADDR),
        .ld_dd       (is_instr && op == OP_DDADDR),
        .ld_val      (xfer_data[AW-1:0]),
        .step        (is_data || (is_shift && !xfer_data[3])),
        .step_up     (is_data ? inc_dir : xfer_data[2]),
        .scroll_step ((is_data && shift_en) || (is_shift && xfer_data[3])),
        .scroll_up   (is_data ? inc_dir : !xfer_data[2]),
        .ac          (ac),
        .cg_sel      (cg_sel),
        .scroll      (scroll)
    );

    assign ram_we     = is_data && !xfer_rw;
    assign ram_re     = is_data && xfer_rw;
    assign ram_clr    = is_instr && op == OP_CLEAR;
    assign ram_addr   = ac;
    assign ram_sel_cg = cg_sel;
    assign ram_wdata  = xfer_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_dir   <= 1'b1;
            shift_en  <= 1'b0;
            disp_on   <= 1'b0;
            cursor_on <= 1'b0;
            blink_on  <= 1'b0;
            bus_8bit  <= 1'b0;
            two_line  <= 1'b0;
            tall_font <= 1'b0;
        end else if (is_instr) begin
            unique case (op)
                OP_ENTRY:   {inc_dir, shift_en} <= xfer_data[1:0];
                OP_DISPCTL: {disp_on, cursor_on, blink_on} <= xfer_data[2:0];
                OP_FUNC:    {bus_8bit, two_line, tall_font} <= xfer_data[4:2];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= is_status || ram_re;
            if (is_status)   rd_data <= {busy, ac};
            else if (ram_re) rd_data <= ram_rdata;
        end
    end

    // R3: a discarded transfer only happens inside a window
    p_drop_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> busy);
    // R3: a discarded transfer leaves the counter and display state alone
    p_drop_no_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> ($stable(ac) && $stable(disp_on) && $stable(inc_dir) && $stable(bus_8bit)));
    // R11: never both RAM strobes at once
    p_ram_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_re}));
    // R4: a status read leaves the counter where it was and reports it
    p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_status |=> (rd_valid && $stable(ac) && rd_data[6:0] == $past(ac)));

endmodule

// File: tb/chardisp_cmd_engine_bench.sv
module chardisp_cmd_engine_bench;

    localparam int TICK  = 2;
    localparam int LONGC = 410 * TICK;
    localparam int SHRTC = 10 * TICK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_valid = 1'b0, xfer_rs = 1'b0, xfer_rw = 1'b0;
    logic [7:0] xfer_data = 8'h00;
    logic rd_valid, busy, dropped, ram_we, ram_re, ram_clr, ram_sel_cg;
    logic [7:0] rd_data, ram_wdata, ram_rdata;
    logic [6:0] ram_addr, scroll;
    logic disp_on, cursor_on, blink_on, inc_dir, shift_en, bus_8bit, two_line, tall_font;

    logic [7:0] dd_mem [128];
    logic [7:0] cg_mem [64];

    int checks = 0, failures = 0;
    logic cap_we, cap_re, cap_clr, cap_drop;
    bit done = 0;

    always #5 clk = ~clk;

    chardisp_cmd_engine #(.TICK_CLKS(TICK)) u_chardisp_cmd_engine (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_rs(xfer_rs),
        .xfer_rw(xfer_rw), .xfer_data(xfer_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .dropped(dropped), .ram_we(ram_we), .ram_re(ram_re), .ram_clr(ram_clr),
        .ram_sel_cg(ram_sel_cg), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .inc_dir(inc_dir), .shift_en(shift_en), .bus_8bit(bus_8bit),
        .two_line(two_line), .tall_font(tall_font), .scroll(scroll)
    );

    assign ram_rdata = ram_sel_cg ? cg_mem[ram_addr[5:0]] : dd_mem[ram_addr];

    always @(posedge clk) begin
        if (ram_we) begin
            if (ram_sel_cg) cg_mem[ram_addr[5:0]] <= ram_wdata;
            else            dd_mem[ram_addr] <= ram_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic rs, input logic rw, input logic [7:0] d);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_rs = rs; xfer_rw = rw; xfer_data = d;
        #1;
        cap_we = ram_we; cap_re = ram_re; cap_clr = ram_clr; cap_drop = dropped;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] d);
        send(1'b0, 1'b0, d);
        wait_ready();
    endtask

    task automatic status(output logic [7:0] v);
        send(1'b0, 1'b1, 8'h00);
        v = rd_data;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [7:0] s;
        status(s);
        chk("R14 status", s, 8'h00);
        chk("R14 inc_dir", inc_dir, 1);
        chk("R14 controls", {disp_on, cursor_on, blink_on, shift_en, bus_8bit, two_line, tall_font}, 0);
        chk("R14 scroll", scroll, 0);
    endtask

    task automatic t_nop();
        send(1'b0, 1'b0, 8'h00);
        chk("R1 nop busy", busy, 0);
        chk("R1 nop drop", cap_drop, 0);
    endtask

    task automatic t_func();
        int n;
        send(1'b0, 1'b0, 8'h38);
        busy_len(n);
        chk("R2 short window", n, SHRTC);
        chk("R9 func 38h", {bus_8bit, two_line, tall_font}, 3'b110);
        cmd(8'h24);
        chk("R9 func 24h", {bus_8bit, two_line, tall_font}, 3'b001);
    endtask

    task automatic t_dispctl();
        cmd(8'h0D);
        chk("R7 dispctl 0Dh", {disp_on, cursor_on, blink_on}, 3'b101);
        cmd(8'h0F);
        chk("R7 dispctl 0Fh", {disp_on, cursor_on, blink_on}, 3'b111);
    endtask

    task automatic t_dd_write();
        logic [7:0] s;
        send(1'b0, 1'b0, 8'hC5);
        status(s);
        chk("R4 status while busy", s, 8'hC5);
        wait_ready();
        status(s);
        chk("R10 text address", s, 8'h45);
        send(1'b1, 1'b0, 8'h41);
        chk("R11 we strobe", cap_we, 1);
        wait_ready();
        chk("R11 text ram", dd_mem[7'h45], 8'h41);
        status(s);
        chk("R11 counter up", s, 8'h46);
    endtask

    task automatic t_dec_wrap();
        logic [7:0] s;
        cmd(8'h04);
        chk("R6 entry 04h", {inc_dir, shift_en}, 2'b00);
        cmd(8'h80);
        send(1'b1, 1'b0, 8'h55);
        wait_ready();
        chk("R11 write at 0", dd_mem[0], 8'h55);
        status(s);
        chk("R11 text wrap down", s, 8'h7F);
    endtask

    task automatic t_cg_wrap();
        logic [7:0] s;
        cmd(8'h06);
        chk("R6 entry 06h", {inc_dir, shift_en}, 2'b10);
        cmd(8'h7F);
        chk("R10 pattern select", ram_sel_cg, 1);
        status(s);
        chk("R10 pattern address", s, 8'h3F);
        send(1'b1, 1'b0, 8'h1F);
        wait_ready();
        chk("R11 pattern ram", cg_mem[63], 8'h1F);
        status(s);
        chk("R11 pattern wrap up", s, 8'h00);
    endtask

    task automatic t_read();
        logic [7:0] s;
        cmd(8'hC5);
        send(1'b1, 1'b1, 8'h00);
        chk("R12 re strobe", cap_re, 1);
        chk("R12 rd_valid", rd_valid, 1);
        chk("R12 read byte", rd_data, 8'h41);
        wait_ready();
        status(s);
        chk("R12 counter step", s, 8'h46);
    endtask

    task automatic t_drop();
        logic [7:0] s;
        send(1'b0, 1'b0, 8'h0C);
        send(1'b0, 1'b0, 8'h08);
        chk("R3 drop flag", cap_drop, 1);
        send(1'b1, 1'b0, 8'hEE);
        chk("R3 data drop flag", cap_drop, 1);
        chk("R3 no write", cap_we, 0);
        wait_ready();
        chk("R3 display kept", {disp_on, cursor_on, blink_on}, 3'b100);
        status(s);
        chk("R3 counter kept", s, 8'h46);
    endtask

    task automatic t_shift();
        logic [7:0] s;
        cmd(8'h18);
        chk("R8 window left", scroll, 1);
        cmd(8'h1C);
        chk("R8 window right", scroll, 0);
        cmd(8'h1C);
        chk("R8 window wrap", scroll, 79);
        cmd(8'h90);
        cmd(8'h14);
        status(s);
        chk("R8 cursor right", s, 8'h11);
        cmd(8'h10);
        status(s);
        chk("R8 cursor left", s, 8'h10);
    endtask

    task automatic t_autoscroll();
        logic [7:0] s;
        cmd(8'h07);
        send(1'b1, 1'b0, 8'h33);
        wait_ready();
        chk("R13 scroll wrap up", scroll, 0);
        status(s);
        chk("R13 counter moves too", s, 8'h11);
        cmd(8'h05);
        send(1'b1, 1'b0, 8'h34);
        wait_ready();
        chk("R13 scroll down", scroll, 79);
    endtask

    task automatic t_clear_home();
        logic [7:0] s;
        int n;
        send(1'b0, 1'b0, 8'h01);
        chk("R5 clear pulse", cap_clr, 1);
        busy_len(n);
        chk("R2 long window clear", n, LONGC);
        chk("R5 scroll reset", scroll, 0);
        status(s);
        chk("R5 counter zero", s, 8'h00);
        cmd(8'h18);
        cmd(8'h7A);
        send(1'b0, 1'b0, 8'h03);
        chk("R1 03h is home", cap_clr, 0);
        busy_len(n);
        chk("R2 long window home", n, LONGC);
        chk("R5 home text space", {ram_sel_cg, scroll}, 0);
        status(s);
        chk("R5 home counter", s, 8'h00);
        cmd(8'hFF);
        status(s);
        chk("R1 FFh is text address", {ram_sel_cg, s}, 9'h07F);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) dd_mem[i] = 8'h00;
        for (int i = 0; i < 64; i++)  cg_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nop();
        t_func();
        t_dispctl();
        t_dd_write();
        t_dec_wrap();
        t_cg_wrap();
        t_read();
        t_drop();
        t_shift();
        t_autoscroll();
        t_clear_home();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule